// File: doc/BRIEF.md
# Misaligned Load/Store Pair Splitter

This block takes one load or store request, made of a byte address and a byte length, and turns it into a pair of sub-requests. Each sub-request covers one 16-byte window. It is named by a window tag, which is the address with its four low bits removed, and by a 16-bit map with one bit per byte of that window. The length is first turned into a unary run of ones. The run is then moved up by the byte offset within the window, into a map twice the window width. The lower half of that map belongs to the request's own window. The upper half belongs to the next window.

A later stage can then compare accesses byte by byte, even when an access crosses a window boundary. The two lanes of one pair always name adjacent windows, so they never conflict with each other.

The request side uses a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output register is empty, or when it is being drained in the same cycle. Both lanes share one registered output handshake. A pair stays on the outputs, unchanged, until `out_ready` is seen high together with `out_valid`.

Top module: `lsp_splitter`

## Requirements
- R1: After reset, `out_valid`, `lane0_valid` and `lane1_valid` are 0 and `req_ready` is 1.
- R2: `req_ready` equals `!out_valid || out_ready` in every cycle.
- R3: A request accepted on a clock edge is presented with `out_valid` = 1 right after that edge. While `out_valid` = 1 and `out_ready` = 0, all output values hold unchanged.
- R4: For a legal request, `lane0_tag` = `req_addr[ADDR_W-1:4]` and `lane0_valid` = 1. `lane0_map` bit b is set exactly when `off <= b < off+len`, where `off` = `req_addr[3:0]`.
- R5: `lane1_tag` = `lane0_tag + 1`. `lane1_map` bit b is set exactly when `off <= b+16 < off+len`.
- R6: `lane1_valid` is 1 only when `lane1_map` is non-zero. An access that lies wholly inside one window gives `lane1_valid` = 0 and `lane1_map` = 0.
- R7: A length of 0, or a length above 8, is illegal. Such a request is still accepted and presented, but with both lane maps zero and both lane valids 0.
- R8: The tag increment wraps modulo 2^(ADDR_W-4): an all-ones tag gives `lane1_tag` = 0, with no error indication.
- R9: When a pair is consumed and no request arrives in the same cycle, `out_valid` becomes 0 after that edge.
- R10: `lane0_valid` or `lane1_valid` is 1 only while `out_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | ADDR_W | Byte address of the access |
| req_len | input | LEN_W | Access length in bytes, 1 to 8 legal |
| out_valid | output | 1 | A sub-request pair is presented |
| out_ready | input | 1 | Consumer takes the pair this cycle |
| lane0_valid | output | 1 | Own-window lane carries bytes |
| lane0_tag | output | ADDR_W-4 | Own window tag |
| lane0_map | output | 16 | Byte map in own window |
| lane1_valid | output | 1 | Next-window lane carries bytes |
| lane1_tag | output | ADDR_W-4 | Own window tag plus one, wrapping |
| lane1_map | output | 16 | Byte map in next window |

## Verification
Every result sits one register behind its request: a pair taken on a rising edge is due right after that edge. So the bench drives inputs on the falling edge and samples the outputs on the next falling edge. The `req_ready` check is combinational, so it is sampled in the same half-cycle in which `out_ready` changes. The back-pressure scenario holds `out_ready` low for several cycles and checks at every falling edge that the pair does not change. It then releases `out_ready` and checks that the waiting request appears one edge later.

// File: rtl/lsp_pkg.sv
package lsp_pkg;
  localparam int LSP_ADDR_W  = 32;
  localparam int LSP_OFFS_W  = 4;
  localparam int LSP_LEN_W   = 4;
  localparam int LSP_MAX_LEN = 8;
  localparam int LSP_LANES   = 2;
endpackage

// File: rtl/lsp_mask_gen.sv
module lsp_mask_gen #(
  parameter int OFFS_W  = 4,
  parameter int LEN_W   = 4,
  parameter int MAX_LEN = 8,
  localparam int WIN    = 1 << OFFS_W,
  localparam int MAP_W  = 2 * WIN
) (
  input  logic [OFFS_W-1:0] off,
  input  logic [LEN_W-1:0]  len,
  output logic              legal,
  output logic [WIN-1:0]    map_lo,
  output logic [WIN-1:0]    map_hi
);
  logic [MAP_W-1:0] unary;
  logic [MAP_W-1:0] placed;

  always_comb begin
    legal  = (len != '0) && (int'(len) <= MAX_LEN);
    unary  = legal ? ((MAP_W'(1) << len) - MAP_W'(1)) : '0;
    placed = unary << off;
    map_lo = placed[WIN-1:0];
    map_hi = placed[MAP_W-1:WIN];
  end
endmodule

// File: rtl/lsp_tag_step.sv
module lsp_tag_step #(
  parameter int TAG_W = 28
) (
  input  logic [TAG_W-1:0] tag,
  output logic [TAG_W-1:0] tag_next
);
  always_comb tag_next = tag + TAG_W'(1);
endmodule

// File: rtl/lsp_out_stage.sv
module lsp_out_stage #(
  parameter int LANES = 2,
  parameter int TAG_W = 28,
  parameter int WIN   = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [LANES-1:0]            in_lane_v,
  input  logic [LANES-1:0][TAG_W-1:0] in_tag,
  input  logic [LANES-1:0][WIN-1:0]   in_map,
  output logic                        q_valid,
  input  logic                        q_ready,
  output logic [LANES-1:0]            q_lane_v,
  output logic [LANES-1:0][TAG_W-1:0] q_tag,
  output logic [LANES-1:0][WIN-1:0]   q_map
);
  logic take;
  assign in_ready = !q_valid || q_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q_valid <= 1'b0;
    else if (take)     q_valid <= 1'b1;
    else if (q_ready)  q_valid <= 1'b0;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_lane_v[g] <= 1'b0;
        q_tag[g]    <= '0;
        q_map[g]    <= '0;
      end else if (take) begin
        q_lane_v[g] <= in_lane_v[g];
        q_tag[g]    <= in_tag[g];
        q_map[g]    <= in_map[g];
      end else if (q_ready) begin
        q_lane_v[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lsp_splitter.sv
module lsp_splitter
  import lsp_pkg::*;
#(
  parameter int ADDR_W  = LSP_ADDR_W,
  parameter int OFFS_W  = LSP_OFFS_W,
  parameter int LEN_W   = LSP_LEN_W,
  parameter int MAX_LEN = LSP_MAX_LEN,
  localparam int TAG_W     = ADDR_W - OFFS_W,
  localparam int WIN_BYTES = 1 << OFFS_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [LEN_W-1:0]     req_len,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic                 lane0_valid,
  output logic [TAG_W-1:0]     lane0_tag,
  output logic [WIN_BYTES-1:0] lane0_map,
  output logic                 lane1_valid,
  output logic [TAG_W-1:0]     lane1_tag,
  output logic [WIN_BYTES-1:0] lane1_map
);
  logic                                legal;
  logic [WIN_BYTES-1:0]                map_lo, map_hi;
  logic [TAG_W-1:0]                    tag_nxt;
  logic [LSP_LANES-1:0]                st_v, q_v;
  logic [LSP_LANES-1:0][TAG_W-1:0]     st_tag, q_tag;
  logic [LSP_LANES-1:0][WIN_BYTES-1:0] st_map, q_map;

  lsp_mask_gen #(.OFFS_W(OFFS_W), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) mask_i (
    .off(req_addr[OFFS_W-1:0]), .len(req_len),
    .legal(legal), .map_lo(map_lo), .map_hi(map_hi));

  lsp_tag_step #(.TAG_W(TAG_W)) step_i (
    .tag(req_addr[ADDR_W-1:OFFS_W]), .tag_next(tag_nxt));

  always_comb begin
    st_tag[0] = req_addr[ADDR_W-1:OFFS_W];
    st_tag[1] = tag_nxt;
    st_map[0] = map_lo;
    st_map[1] = map_hi;
    st_v[0]   = legal;
    st_v[1]   = |map_hi;
  end

  lsp_out_stage #(.LANES(LSP_LANES), .TAG_W(TAG_W), .WIN(WIN_BYTES)) out_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready),
    .in_lane_v(st_v), .in_tag(st_tag), .in_map(st_map),
    .q_valid(out_valid), .q_ready(out_ready),
    .q_lane_v(q_v), .q_tag(q_tag), .q_map(q_map));

  assign lane0_valid = q_v[0];
  assign lane1_valid = q_v[1];
  assign lane0_tag   = q_tag[0];
  assign lane1_tag   = q_tag[1];
  assign lane0_map   = q_map[0];
  assign lane1_map   = q_map[1];
endmodule

// File: rtl/lsp_splitter_chk.sv
module lsp_splitter_chk #(
  parameter int TAG_W     = 28,
  parameter int WIN_BYTES = 16,
  parameter int MAX_LEN   = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic                 lane0_valid,
  input logic [TAG_W-1:0]     lane0_tag,
  input logic [WIN_BYTES-1:0] lane0_map,
  input logic                 lane1_valid,
  input logic [TAG_W-1:0]     lane1_tag,
  input logic [WIN_BYTES-1:0] lane1_map
);
  int bytes_set;
  assign bytes_set = $countones(lane0_map) + $countones(lane1_map);

  p_ready_rule_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready == (!out_valid || out_ready));
  p_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> out_valid);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(lane0_map) && $stable(lane1_map)
      && $stable(lane0_tag) && $stable(lane1_tag) && $stable(lane0_valid) && $stable(lane1_valid)));
  p_byte_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lane0_valid |-> (bytes_set >= 1 && bytes_set <= MAX_LEN));
  p_tag_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (lane1_tag == lane0_tag + TAG_W'(1)));
  p_lane1_map_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lane1_valid |-> (lane1_map != '0));
  p_illegal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !lane0_valid) |-> (!lane1_valid && lane0_map == '0 && lane1_map == '0));
  p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !req_valid) |=> !out_valid);
  p_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lane0_valid || lane1_valid) |-> out_valid);
endmodule

bind lsp_splitter lsp_splitter_chk #(.TAG_W(TAG_W), .WIN_BYTES(WIN_BYTES), .MAX_LEN(MAX_LEN)) chk_i (.*);

// File: tb/lsp_splitter_tb_top.sv
module lsp_splitter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int TW = AW - 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, out_ready = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic [3:0] req_len = '0;
  logic req_ready, out_valid, lane0_valid, lane1_valid;
  logic [TW-1:0] lane0_tag, lane1_tag;
  logic [15:0] lane0_map, lane1_map;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsp_splitter dut_i (.*);

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // expected byte maps computed byte by byte from the requirements
  task automatic expect_pair(input string req, input logic [AW-1:0] a, input int len);
    logic [15:0] e0, e1;
    int off;
    bit ok;
    off = int'(a[3:0]);
    ok = (len >= 1 && len <= 8);
    e0 = '0; e1 = '0;
    for (int b = 0; b < 32; b++)
      if (ok && b >= off && b < off + len) begin
        if (b < 16) e0[b] = 1'b1; else e1[b-16] = 1'b1;
      end
    chk(req, "out_valid", out_valid, 1);
    chk(req, "lane0_valid", lane0_valid, ok);
    chk(req, "lane0_map", lane0_map, e0);
    chk(req, "lane1_valid", lane1_valid, e1 != 0);
    chk(req, "lane1_map", lane1_map, e1);
    chk(req, "lane0_tag", lane0_tag, a[AW-1:4]);
    chk(req, "lane1_tag", lane1_tag, TW'(a[AW-1:4] + 1));
  endtask

  // one request with out_ready high; sampled at the falling edge after acceptance
  task automatic send(input string req, input logic [AW-1:0] a, input int len);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_len = 4'(len);
    chk(req, "req_ready", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    expect_pair(req, a, len);
  endtask

  task automatic t_reset();
    chk("R1", "out_valid", out_valid, 0);
    chk("R1", "lane0_valid", lane0_valid, 0);
    chk("R1", "lane1_valid", lane1_valid, 0);
    chk("R1", "req_ready", req_ready, 1);
  endtask

  task automatic t_inside();
    send("R4", 32'h0000_0100, 4);
    send("R6", 32'h0000_0208, 8);   // ends exactly at window end
    send("R4", 32'h0000_030F, 1);
  endtask

  task automatic t_spill();
    send("R5", 32'h0000_005B, 8);   // window 5 map F800, window 6 map 0007
    chk("R5", "lane0_map example", lane0_map, 16'hF800);
    chk("R5", "lane1_map example", lane1_map, 16'h0007);
    send("R5", 32'h0000_1239, 8);
    send("R5", 32'h0000_4ABF, 2);
  endtask

  task automatic t_illegal();
    send("R7", 32'h0000_0044, 0);
    send("R7", 32'h0000_004E, 9);
    send("R7", 32'h0000_0040, 15);
  endtask

  task automatic t_wrap();
    send("R8", 32'hFFFF_FFFC, 8);
    chk("R8", "lane1_tag wrap", lane1_tag, 0);
  endtask

  task automatic t_drain();
    @(negedge clk);
    chk("R9", "out_valid", out_valid, 0);
    chk("R10", "lane0_valid", lane0_valid, 0);
    chk("R10", "lane1_valid", lane1_valid, 0);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    out_ready = 1'b0;
    req_valid = 1'b1; req_addr = 32'h0000_0A0D; req_len = 4'd6;
    @(negedge clk);
    expect_pair("R3", 32'h0000_0A0D, 6);
    req_addr = 32'h0000_0B01; req_len = 4'd3;
    chk("R2", "req_ready stalled", req_ready, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      expect_pair("R3", 32'h0000_0A0D, 6);
      chk("R2", "req_ready stalled", req_ready, 0);
    end
    out_ready = 1'b1;
    #1;
    chk("R2", "req_ready draining", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    expect_pair("R3", 32'h0000_0B01, 3);
  endtask

  initial begin
    #(CLK_PERIOD * 2000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2 + 2);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_inside();
    t_spill();
    t_illegal();
    t_wrap();
    t_drain();
    t_backpressure();
    t_drain();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule